// File: doc/BRIEF.md
# Mixed-Format Fixed-Point Add/Subtract Unit

This block is a purely combinational signed fixed-point arithmetic unit whose two operands and single result each carry their own width and their own binary exponent. A port holding the integer `n` with exponent `e` represents the real value `n * 2^e`. The integrator does not pick exponents by hand. For each port the integrator declares a symmetric magnitude range and optionally a width. The block then derives the smallest exponent at which that range still fits in the signed width.

Before combining the operands, the block realigns each one to the result's exponent. A source with a larger exponent than the result is shifted left, which is exact. A source with a smaller exponent is shifted right arithmetically, which discards low bits by rounding toward minus infinity. A three-bit operation code selects one of five functions, all sharing one adder: sum, difference, format-converting copy of the first operand, negation of the first operand, or absolute value of the first operand. No saturation is applied, so a result outside the result format wraps.

Top module: `fxp_addsub`

## Requirements
- R1: Each port's exponent is the smallest integer `e` with `range <= (2^(W-1)-1) * 2^e`, i.e. `ceil(log2(range/(2^(W-1)-1)))`, and the port integer `n` means the value `n*2^e`.
- R2: Any port width left unset takes the common parameter `LONG_W`, which defaults to 25 bits.
- R3: When no result range is given (`Y_RANGE` = 0.0), the result range is the sum of the two operand ranges, so ranges 5 and 10 give 15.
- R4: With `op` = 3'd0 the result is `a + b`, within three result LSBs of the exact sum.
- R5: With `op` = 3'd1 the result is the first operand minus the second (`a - b`), never `b - a`.
- R6: With `op` = 3'd2 the result is `a` converted to the result format, and `b` has no effect.
- R7: With `op` = 3'd3 the result is `-a` in the result format.
- R8: With `op` = 3'd4 the result is `|a|` in the result format.
- R9: The codes 3'd5, 3'd6 and 3'd7 drive the result to zero, whatever the operand values.
- R10: An operand whose exponent exceeds the result exponent is shifted left with no loss. An operand whose exponent is smaller is shifted right arithmetically, giving `floor(n / 2^k)` for a shift of `k`.
- R11: Overflow wraps: the result is the low `Y_W` bits of the exact sum of the aligned operands.
- R12: Overriding `Y_W` alone keeps the automatic result range and moves the result exponent to match, so a wider result has finer resolution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | A_W | First operand, signed integer scaled by 2^A_E |
| b | input | B_W | Second operand, signed integer scaled by 2^B_E |
| op | input | 3 | Operation code: 0 add, 1 subtract, 2 copy, 3 negate, 4 absolute, 5 to 7 zero |
| y | output | Y_W | Result, signed integer scaled by 2^Y_E |

## Verification
Right-shift truncation of an operand and wrap of the sum can both act on the same result. The bench provokes this with an instance whose result is only 8 bits wide and covers a range of 2.0. It drives operands whose aligned sum exceeds that range, and it also drives negative operands that carry nonzero bits below the result LSB. For each such case the bench builds the expected integer itself, applying floor to each scaled operand and then reducing the sum modulo 256. The result must match that integer exactly, not merely fall within a tolerance.

// File: rtl/fxp_pkg.sv
package fxp_pkg;

   typedef enum logic [2:0] {
      FXP_ADD  = 3'd0,
      FXP_SUB  = 3'd1,
      FXP_COPY = 3'd2,
      FXP_NEG  = 3'd3,
      FXP_ABS  = 3'd4
   } fxp_op_e;

   // Smallest exponent e such that rng <= (2^(width-1)-1) * 2^e  (R1)
   function automatic int exp_for_range(real rng, int width);
      real cap;
      int  e;
      cap = (2.0 ** (width - 1)) - 1.0;
      e   = 0;
      if (rng <= 0.0) return 0;
      while (rng > cap) begin
         e   = e + 1;
         cap = cap * 2.0;
      end
      while (rng <= cap / 2.0) begin
         e   = e - 1;
         cap = cap / 2.0;
      end
      return e;
   endfunction

   function automatic int imax(int x, int y);
      return (x > y) ? x : y;
   endfunction

endpackage

// File: rtl/fxp_align.sv
// Moves a signed fixed-point value from exponent IN_E to exponent OUT_E (R10)
module fxp_align #(
   parameter int IN_W  = 8,
   parameter int IN_E  = 0,
   parameter int OUT_W = 8,
   parameter int OUT_E = 0
) (
   input  logic signed [IN_W-1:0]  din,
   output logic signed [OUT_W-1:0] dout
);
   localparam int SHIFT = IN_E - OUT_E;

   generate
      if (SHIFT >= 0) begin : g_shl
         if (OUT_W < IN_W + SHIFT) begin : g_bad_w
            $error("fxp_align: output too narrow for lossless left shift");
         end
         logic signed [OUT_W-1:0] ext;
         assign ext  = OUT_W'(din);
         assign dout = ext <<< SHIFT;
      end else begin : g_shr
         localparam int RSH = -SHIFT;
         logic signed [IN_W-1:0] shr;
         assign shr  = din >>> RSH;
         assign dout = OUT_W'(shr);
      end
   endgenerate
endmodule

// File: rtl/fxp_opsel.sv
// Maps the operation code onto one adder: lhs +/- rhs
module fxp_opsel
   import fxp_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [2:0]       op,
   input  logic signed [W-1:0] a_al,
   input  logic signed [W-1:0] b_al,
   output logic signed [W-1:0] lhs,
   output logic signed [W-1:0] rhs,
   output logic             sub
);
   always_comb begin
      lhs = '0;
      rhs = '0;
      sub = 1'b0;
      case (fxp_op_e'(op))
         FXP_ADD: begin
            lhs = a_al;
            rhs = b_al;
         end
         FXP_SUB: begin
            lhs = a_al;
            rhs = b_al;
            sub = 1'b1;
         end
         FXP_COPY: lhs = a_al;
         FXP_NEG: begin
            rhs = a_al;
            sub = 1'b1;
         end
         FXP_ABS: begin
            if (a_al[W-1]) begin
               rhs = a_al;
               sub = 1'b1;
            end else begin
               lhs = a_al;
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/fxp_addcore.sv
// Wide add/subtract, result taken as the low OUT_W bits (wraps, R11)
module fxp_addcore #(
   parameter int W     = 9,
   parameter int OUT_W = 8
) (
   input  logic signed [W-1:0]     lhs,
   input  logic signed [W-1:0]     rhs,
   input  logic                    sub,
   output logic signed [OUT_W-1:0] res
);
   generate
      if (OUT_W > W) begin : g_bad_w
         $error("fxp_addcore: result wider than internal sum");
      end
   endgenerate

   logic signed [W-1:0] total;
   assign total = sub ? (lhs - rhs) : (lhs + rhs);
   assign res   = total[OUT_W-1:0];
endmodule

// File: rtl/fxp_addsub.sv
module fxp_addsub
   import fxp_pkg::*;
#(
   parameter int  LONG_W  = 25,
   parameter int  A_W     = LONG_W,
   parameter int  B_W     = LONG_W,
   parameter int  Y_W     = LONG_W,
   parameter real A_RANGE = 5.0,
   parameter real B_RANGE = 10.0,
   parameter real Y_RANGE = 0.0
) (
   input  logic signed [A_W-1:0] a,
   input  logic signed [B_W-1:0] b,
   input  logic [2:0]            op,
   output logic signed [Y_W-1:0] y
);
   // Result range falls back to the sum of operand ranges (R3)
   localparam real Y_RANGE_EFF = (Y_RANGE > 0.0) ? Y_RANGE : (A_RANGE + B_RANGE);
   localparam int  A_E   = exp_for_range(A_RANGE, A_W);
   localparam int  B_E   = exp_for_range(B_RANGE, B_W);
   localparam int  Y_E   = exp_for_range(Y_RANGE_EFF, Y_W);
   localparam int  A_UP  = imax(A_E - Y_E, 0);
   localparam int  B_UP  = imax(B_E - Y_E, 0);
   localparam int  INT_W = imax(imax(A_W + A_UP, B_W + B_UP) + 1, Y_W);

   generate
      if (A_W < 2 || B_W < 2 || Y_W < 2) begin : g_bad_w
         $error("fxp_addsub: every port needs at least two bits");
      end
      if (A_RANGE <= 0.0 || B_RANGE <= 0.0 || Y_RANGE < 0.0) begin : g_bad_rng
         $error("fxp_addsub: ranges must be positive");
      end
   endgenerate

   logic signed [INT_W-1:0] a_al;
   logic signed [INT_W-1:0] b_al;
   logic signed [INT_W-1:0] lhs;
   logic signed [INT_W-1:0] rhs;
   logic                    sub;

   fxp_align #(.IN_W(A_W), .IN_E(A_E), .OUT_W(INT_W), .OUT_E(Y_E)) u_align_a (
      .din (a),
      .dout(a_al)
   );

   fxp_align #(.IN_W(B_W), .IN_E(B_E), .OUT_W(INT_W), .OUT_E(Y_E)) u_align_b (
      .din (b),
      .dout(b_al)
   );

   fxp_opsel #(.W(INT_W)) u_opsel (
      .op  (op),
      .a_al(a_al),
      .b_al(b_al),
      .lhs (lhs),
      .rhs (rhs),
      .sub (sub)
   );

   fxp_addcore #(.W(INT_W), .OUT_W(Y_W)) u_core (
      .lhs(lhs),
      .rhs(rhs),
      .sub(sub),
      .res(y)
   );
endmodule

// File: rtl/fxp_addsub_chk.sv
module fxp_addsub_chk #(
   parameter int A_W   = 25,
   parameter int Y_W   = 25,
   parameter int INT_W = 26,
   parameter int A_SHL = 0
) (
   input logic [2:0]              op,
   input logic signed [A_W-1:0]   a,
   input logic signed [INT_W-1:0] a_al,
   input logic signed [INT_W-1:0] b_al,
   input logic signed [Y_W-1:0]   y
);
   logic signed [INT_W-1:0] w_add;
   logic signed [INT_W-1:0] w_sub;
   logic signed [INT_W-1:0] w_neg;
   logic signed [INT_W-1:0] w_abs;

   assign w_add = a_al + b_al;
   assign w_sub = a_al - b_al;
   assign w_neg = -a_al;
   assign w_abs = a_al[INT_W-1] ? -a_al : a_al;

   always_comb begin
      if (op == 3'd0)
         p_add_wrap_r4: assert (y == w_add[Y_W-1:0]);
      if (op == 3'd1)
         p_sub_order_r5: assert (y == w_sub[Y_W-1:0]);
      if (op == 3'd2)
         p_copy_r6: assert (y == a_al[Y_W-1:0]);
      if (op == 3'd3)
         p_neg_r7: assert (y == w_neg[Y_W-1:0]);
      if (op == 3'd4)
         p_abs_r8: assert (y == w_abs[Y_W-1:0]);
      if (op > 3'd4)
         p_unused_zero_r9: assert (y == '0);
   end

   generate
      if (A_SHL >= 0) begin : g_left
         logic signed [INT_W-1:0] a_ext;
         assign a_ext = INT_W'(a);
         always_comb begin
            p_left_exact_r10: assert ((a_al >>> A_SHL) == a_ext);
         end
      end
   endgenerate
endmodule

bind fxp_addsub fxp_addsub_chk #(
   .A_W  (A_W),
   .Y_W  (Y_W),
   .INT_W(INT_W),
   .A_SHL(A_E - Y_E)
) u_chk (
   .op  (op),
   .a   (a),
   .a_al(a_al),
   .b_al(b_al),
   .y   (y)
);

// File: tb/fxp_addsub_bench.sv
`timescale 1ns/1ps
module fxp_addsub_bench;
   logic clk = 1'b0;
   logic rst_n;
   always #2 clk = ~clk;   // 250 MHz

   logic signed [24:0] a;
   logic signed [24:0] b;
   logic [2:0]         op;
   logic signed [24:0] y0;
   logic signed [39:0] y1;
   logic signed [7:0]  y2;

   int n_cmp = 0;
   int n_bad = 0;
   int AE, BE, Y0E, Y1E, Y2E;

   // default formats: ranges 5 and 10, 25-bit everywhere
   fxp_addsub u_fxp_addsub (.a(a), .b(b), .op(op), .y(y0));
   // result width raised to 40 bits, range still automatic
   fxp_addsub #(.Y_W(40)) u_fxp_addsub_fine (.a(a), .b(b), .op(op), .y(y1));
   // narrow result: range 2.0 in 8 bits
   fxp_addsub #(.Y_W(8), .Y_RANGE(2.0)) u_fxp_addsub_wrap (.a(a), .b(b), .op(op), .y(y2));

   function automatic int bexp(real rng, int w);
      return int'($ceil($ln(rng / ((2.0 ** (w - 1)) - 1.0)) / $ln(2.0)));
   endfunction

   function automatic real av();  return real'(a) * (2.0 ** AE);   endfunction
   function automatic real bv();  return real'(b) * (2.0 ** BE);   endfunction
   function automatic real y0v(); return real'(y0) * (2.0 ** Y0E); endfunction
   function automatic real y1v(); return real'(y1) * (2.0 ** Y1E); endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic chk_real(input string tag, input real got, input real want, input real tol);
      n_cmp++;
      if ((got - want > tol) || (want - got > tol)) begin
         n_bad++;
         $display("FAIL %s: actual %0.9f expected %0.9f", tag, got, want);
      end
   endtask

   task automatic chk_int(input string tag, input longint got, input longint want);
      n_cmp++;
      if (got != want) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, got, want);
      end
   endtask

   task automatic apply(input real ar, input real br, input logic [2:0] o);
      @(negedge clk);
      a  = 25'($rtoi(ar * (2.0 ** (-AE))));
      b  = 25'($rtoi(br * (2.0 ** (-BE))));
      op = o;
      @(posedge clk);
      #1;
   endtask

   task automatic apply_int(input int ai, input int bi, input logic [2:0] o);
      @(negedge clk);
      a  = 25'(ai);
      b  = 25'(bi);
      op = o;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      chk_int("R4 zero inputs after reset", longint'(y0), 0);
   endtask

   task automatic t_add();
      real lsb = 2.0 ** Y0E;
      apply(1.23, 4.56, 3'd0);
      chk_real("R4 R1 add small", y0v(), av() + bv(), 3.0 * lsb);
      apply(-3.3, 7.7, 3'd0);
      chk_real("R4 add mixed sign", y0v(), av() + bv(), 3.0 * lsb);
      apply(4.99, 9.99, 3'd0);
      chk_real("R2 R3 add near top of range", y0v(), av() + bv(), 3.0 * lsb);
      apply(-4.99, -9.99, 3'd0);
      chk_real("R3 add near bottom of range", y0v(), av() + bv(), 3.0 * lsb);
   endtask

   task automatic t_sub();
      real lsb = 2.0 ** Y0E;
      apply(1.0, 6.0, 3'd1);
      chk_real("R5 sub a-b", y0v(), av() - bv(), 3.0 * lsb);
      apply(-2.5, 3.25, 3'd1);
      chk_real("R5 sub negative lhs", y0v(), av() - bv(), 3.0 * lsb);
   endtask

   task automatic t_copy();
      real lsb = 2.0 ** Y0E;
      apply(3.14, 9.0, 3'd2);
      chk_real("R6 copy ignores b", y0v(), av(), 2.0 * lsb);
      apply(3.14, -7.0, 3'd2);
      chk_real("R6 copy with other b", y0v(), av(), 2.0 * lsb);
   endtask

   task automatic t_neg();
      real lsb = 2.0 ** Y0E;
      apply(2.5, 1.0, 3'd3);
      chk_real("R7 negate positive", y0v(), -av(), 2.0 * lsb);
      apply(-4.0, 1.0, 3'd3);
      chk_real("R7 negate negative", y0v(), -av(), 2.0 * lsb);
   endtask

   task automatic t_abs();
      real lsb = 2.0 ** Y0E;
      apply(-3.75, 2.0, 3'd4);
      chk_real("R8 abs negative", y0v(), -av(), 2.0 * lsb);
      apply(1.5, -2.0, 3'd4);
      chk_real("R8 abs positive", y0v(), av(), 2.0 * lsb);
   endtask

   task automatic t_unused();
      for (int c = 5; c < 8; c++) begin
         apply(4.0, 8.0, 3'(c));
         chk_int($sformatf("R9 code %0d gives zero", c), longint'(y0), 0);
      end
   endtask

   task automatic t_fine();
      apply(1.23, 4.56, 3'd2);
      // left shifts only: exact copy (R10, R12)
      chk_real("R12 R10 fine copy exact", y1v(), av(), 0.0);
      apply(1.23, 4.56, 3'd0);
      chk_real("R12 fine add exact", y1v(), av() + bv(), 0.0);
      chk_int("R12 R1 fine result exponent", Y1E, -35);
   endtask

   task automatic t_wrap_floor();
      int     ka = Y2E - AE;
      int     kb = Y2E - BE;
      longint s;
      apply_int(-65537, 0, 3'd2);
      chk_int("R10 floor negative", longint'(y2), longint'($floor(real'(a) / (2.0 ** ka))));
      apply_int(65536 * 3 + 65535, 0, 3'd2);
      chk_int("R10 floor positive", longint'(y2), 3);
      apply(4.0, 3.0, 3'd0);
      s = longint'($floor(real'(a) / (2.0 ** ka))) + longint'($floor(real'(b) / (2.0 ** kb)));
      s = ((s + 128) % 256 + 256) % 256 - 128;
      chk_int("R11 wrap positive overflow", longint'(y2), s);
      apply_int(-(1 << 23) - 12345, -(3 << 20) - 777, 3'd0);
      s = longint'($floor(real'(a) / (2.0 ** ka))) + longint'($floor(real'(b) / (2.0 ** kb)));
      s = ((s + 128) % 256 + 256) % 256 - 128;
      chk_int("R11 R10 wrap with floor", longint'(y2), s);
   endtask

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      AE  = bexp(5.0, 25);
      BE  = bexp(10.0, 25);
      Y0E = bexp(15.0, 25);
      Y1E = bexp(15.0, 40);
      Y2E = bexp(2.0, 8);
      rst_n = 1'b0;
      a  = '0;
      b  = '0;
      op = 3'd0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_add();
      t_sub();
      t_copy();
      t_neg();
      t_abs();
      t_unused();
      t_fine();
      t_wrap_floor();
      summary();
      $finish;
   end
endmodule